// File: doc/BRIEF.md
# Dual Symmetric FIR Filter with Folded Delay Lines

The block runs two independent 8-tap even-symmetric FIR filters, channel A and channel B, side by side. Each channel has its own stream of 10-bit signed samples, qualified by its own valid strobe. The delay line is folded, so the two samples that meet the same coefficient are summed first. Eight taps therefore cost only four multipliers per channel.

Coefficients are signed 10-bit values. Only the four unique ones are stored per channel. They sit in a bank of 32 sets, loaded over a small write port of address, data and strobe. A 5-bit select names the set that both channels use. A 2-bit route control chooses which channel, if either, drives the shared 19-bit result bus. That bus carries bits 27 down to 9 of the full 28-bit sum. Each result depends only on the eight newest accepted samples of its channel; nothing is accumulated from earlier results.

Top module: `dual_sym_fir`

## Requirements
- R1: After reset, `out_vld` is 0, `out_data` is 0 and every stored coefficient is 0, so the first results are 0.
- R2: With s7 the newest accepted sample of a channel and s0 the oldest of its eight, the full sum is (s7+s0)·K0 + (s6+s1)·K1 + (s5+s2)·K2 + (s4+s3)·K3, taken as signed two's complement. `out_data` carries bits 27..9 of that 28-bit sum.
- R3: A channel's delay line advances only in a cycle where its valid strobe is high. Idle cycles between samples do not change later results.
- R4: A sample accepted at clock edge P gives its result, with `out_vld` high, right after edge P+4, when its channel is routed to the output.
- R5: A write with `cw_en` high and `cw_addr[8]`=1 stores `cw_data` into one coefficient. Set = `cw_addr[7:3]`, channel = `cw_addr[2]` (0 for A, 1 for B), index Kn with n = `cw_addr[1:0]`. Set 0 of A is therefore 0x100..0x103, and set 0 of B is 0x104..0x107.
- R6: A write with `cw_addr[8]`=0 changes no coefficient.
- R7: `coef_sel` picks the coefficient set used by both channels; 0 selects set 0.
- R8: `out_sel` = 2'b00 routes channel A and 2'b01 routes channel B. With `out_sel[1]`=1, `out_vld` stays 0 and `out_data` holds its last value.
- R9: The two channels are independent. Samples of one never enter the other's result.
- R10: Full-scale inputs (samples and coefficients of -512) give the exact result with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | Channel A sample strobe |
| a_samp | input | 10 | Channel A signed sample |
| b_vld | input | 1 | Channel B sample strobe |
| b_samp | input | 10 | Channel B signed sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 9 | Coefficient write address |
| cw_data | input | 10 | Coefficient write value, signed |
| coef_sel | input | 5 | Active coefficient set |
| out_sel | input | 2 | Output routing control |
| out_vld | output | 1 | Result valid |
| out_data | output | 19 | Result, sum bits 27..9 |

## Verification
The assertions assume that `coef_sel` and `out_sel` stay steady while samples are still inside the four-stage pipe. They also assume that coefficient writes do not land in a set while that set is feeding samples in flight. The stimulus respects this: it changes routing, set selection and coefficients only after at least eight idle cycles have drained both channels. Between those quiet points it drives random samples with random gaps on both channels at once.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int SAMP_W  = 10;
    localparam int COEF_W  = 10;
    localparam int N_UNIQ  = 4;
    localparam int N_TAPS  = 2 * N_UNIQ;
    localparam int IDX_W   = $clog2(N_UNIQ);
    localparam int SET_W   = 5;
    localparam int N_SETS  = 1 << SET_W;
    localparam int N_CHAN  = 2;
    localparam int ADDR_W  = IDX_W + 1 + SET_W + 1;
    localparam int PRE_W   = SAMP_W + 1;
    localparam int PROD_W  = PRE_W + COEF_W;
    localparam int SUM_W   = 28;
    localparam int OUT_LSB = 9;
    localparam int OUT_W   = SUM_W - OUT_LSB;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PRE_W-1:0]  pre_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [N_UNIQ-1:0][COEF_W-1:0] coef_vec_t;

    typedef enum logic [1:0] {
        ROUTE_A    = 2'b00,
        ROUTE_B    = 2'b01,
        ROUTE_OFF0 = 2'b10,
        ROUTE_OFF1 = 2'b11
    } route_e;

    typedef struct packed {
        logic             hit;
        logic [SET_W-1:0] set;
        logic             chan;
        logic [IDX_W-1:0] idx;
    } cw_dec_t;

    function automatic cw_dec_t decode_cw(input logic [ADDR_W-1:0] a);
        cw_dec_t d;
        d.hit  = a[ADDR_W-1];
        d.set  = a[ADDR_W-2 -: SET_W];
        d.chan = a[IDX_W];
        d.idx  = a[IDX_W-1:0];
        return d;
    endfunction

    function automatic logic [OUT_W-1:0] out_slice(input sum_t s);
        return s[SUM_W-1:OUT_LSB];
    endfunction

endpackage

// File: rtl/dsf_coef_bank.sv
module dsf_coef_bank
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    output coef_vec_t         coef_a,
    output coef_vec_t         coef_b
);

    logic [COEF_W-1:0] mem [N_SETS][N_CHAN][N_UNIQ];
    cw_dec_t dec;

    assign dec = decode_cw(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SETS; s++)
                for (int c = 0; c < N_CHAN; c++)
                    for (int i = 0; i < N_UNIQ; i++)
                        mem[s][c][i] <= '0;
        end else if (wr_en && dec.hit) begin
            mem[dec.set][dec.chan][dec.idx] <= wr_data;
        end
    end

    for (genvar i = 0; i < N_UNIQ; i++) begin : g_rd
        assign coef_a[i] = mem[rd_set][0][i];
        assign coef_b[i] = mem[rd_set][1][i];
    end

    // R5: an in-range write lands in the addressed slot
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.hit) |=>
        (mem[$past(dec.set)][$past(dec.chan)][$past(dec.idx)] == $past(wr_data)));

    // R6: an out-of-range write leaves the read ports untouched
    p_oob_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.hit) ##1 $stable(rd_set) |->
        ($stable(coef_a) && $stable(coef_b)));

endmodule

// File: rtl/dsf_channel.sv
module dsf_channel
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_vld,
    input  samp_t     in_samp,
    input  coef_vec_t coefs,
    output logic      sum_vld,
    output sum_t      sum_out
);

    samp_t taps [N_TAPS];
    pre_t  pre_q [N_UNIQ];
    coef_t coef_q [N_UNIQ];
    prod_t prod_q [N_UNIQ];
    sum_t  tree;
    logic  v0, v1, v2;

    // folded delay line, taps[N_TAPS-1] is the newest sample
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TAPS; i++) taps[i] <= '0;
            v0 <= 1'b0;
        end else begin
            v0 <= in_vld;
            if (in_vld) begin
                taps[N_TAPS-1] <= in_samp;
                for (int i = 0; i < N_TAPS-1; i++) taps[i] <= taps[i+1];
            end
        end
    end

    // pre-add mirrored pairs, then multiply
    for (genvar k = 0; k < N_UNIQ; k++) begin : g_mac
        always_ff @(posedge clk) begin
            if (rst) begin
                pre_q[k]  <= '0;
                coef_q[k] <= '0;
                prod_q[k] <= '0;
            end else begin
                pre_q[k]  <= pre_t'(taps[N_TAPS-1-k]) + pre_t'(taps[k]);
                coef_q[k] <= coef_t'(coefs[k]);
                prod_q[k] <= prod_t'(pre_q[k]) * prod_t'(coef_q[k]);
            end
        end
    end

    always_comb begin
        tree = '0;
        for (int k = 0; k < N_UNIQ; k++) tree = tree + sum_t'(prod_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1      <= 1'b0;
            v2      <= 1'b0;
            sum_vld <= 1'b0;
            sum_out <= '0;
        end else begin
            v1      <= v0;
            v2      <= v1;
            sum_vld <= v2;
            sum_out <= tree;
        end
    end

    // R3: an accepted sample enters at the newest end, the rest move one place
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (taps[N_TAPS-1] == $past(in_samp)) &&
                   (taps[N_TAPS-2] == $past(taps[N_TAPS-1])));

    // R3: no strobe, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(taps[0]) && $stable(taps[N_TAPS-1]));

    // R4: a sum is only flagged four edges after a strobe
    p_sum_latency_r4: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> $past(in_vld, 4));

endmodule

// File: rtl/dual_sym_fir.sv
module dual_sym_fir
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_vld,
    input  logic [SAMP_W-1:0] a_samp,
    input  logic              b_vld,
    input  logic [SAMP_W-1:0] b_samp,
    input  logic              cw_en,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic [COEF_W-1:0] cw_data,
    input  logic [SET_W-1:0]  coef_sel,
    input  logic [1:0]        out_sel,
    output logic              out_vld,
    output logic [OUT_W-1:0]  out_data
);

    coef_vec_t coef_a, coef_b;
    logic      a_sum_vld, b_sum_vld;
    sum_t      a_sum, b_sum;
    route_e    route;

    assign route = route_e'(out_sel);

    dsf_coef_bank i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .rd_set  (coef_sel),
        .coef_a  (coef_a),
        .coef_b  (coef_b)
    );

    dsf_channel i_chan_a (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (a_vld),
        .in_samp (samp_t'(a_samp)),
        .coefs   (coef_a),
        .sum_vld (a_sum_vld),
        .sum_out (a_sum)
    );

    dsf_channel i_chan_b (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (b_vld),
        .in_samp (samp_t'(b_samp)),
        .coefs   (coef_b),
        .sum_vld (b_sum_vld),
        .sum_out (b_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            case (route)
                ROUTE_A: begin
                    out_vld <= a_sum_vld;
                    if (a_sum_vld) out_data <= out_slice(a_sum);
                end
                ROUTE_B: begin
                    out_vld <= b_sum_vld;
                    if (b_sum_vld) out_data <= out_slice(b_sum);
                end
                default: out_vld <= 1'b0;
            endcase
        end
    end

    // R8: routing switched off never flags a result
    p_route_off_r8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> !$past(out_sel[1]));

    // R8: while off, the bus holds
    p_route_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_sel[1] |=> $stable(out_data));

    // R4, R9: a result comes from a strobe of the routed channel five edges back
    p_out_latency_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (($past(out_sel) == 2'b00) && $past(a_vld, 5)) ||
                    (($past(out_sel) == 2'b01) && $past(b_vld, 5)));

endmodule

// File: tb/test_dual_sym_fir.sv
module test_dual_sym_fir;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_vld = 1'b0, b_vld = 1'b0;
    logic [9:0]  a_samp = '0, b_samp = '0;
    logic        cw_en = 1'b0;
    logic [8:0]  cw_addr = '0;
    logic [9:0]  cw_data = '0;
    logic [4:0]  coef_sel = '0;
    logic [1:0]  out_sel = 2'b00;
    logic        out_vld;
    logic [18:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ha [8];
    int hb [8];
    int cm [32][2][4];
    int qv [$];
    int qd [$];
    string qt [$];
    logic [18:0] last_data = '0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    dual_sym_fir i_dual_sym_fir (
        .clk(clk), .rst(rst),
        .a_vld(a_vld), .a_samp(a_samp), .b_vld(b_vld), .b_samp(b_samp),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .coef_sel(coef_sel), .out_sel(out_sel),
        .out_vld(out_vld), .out_data(out_data)
    );

    function automatic int model_out(input int h [8], input int set, input int ch);
        longint s = 0;
        for (int k = 0; k < 4; k++) s += longint'(h[7-k] + h[k]) * longint'(cm[set][ch][k]);
        return int'((s >>> 9) & 64'h7FFFF);
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic check_out();
        if (out_vld) begin
            if (qv.size() == 0) check("R8 unexpected valid", 1, 0);
            else begin
                check({qt[0], " data"}, int'(out_data), qv[0]);
                check({qt[0], " R4 timing"}, cyc, qd[0]);
                void'(qv.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
            end
            last_data = out_data;
        end else if (qv.size() != 0 && qd[0] <= cyc) begin
            check({qt[0], " R4 missing valid"}, 0, 1);
            void'(qv.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
        end
    endtask

    task automatic step(input bit av, input int as, input bit bv, input int bs, input string tag);
        @(negedge clk);
        check_out();
        a_vld = av; a_samp = 10'(as);
        b_vld = bv; b_samp = 10'(bs);
        cw_en = 1'b0;
        if (av) begin
            for (int i = 0; i < 7; i++) ha[i] = ha[i+1];
            ha[7] = as;
            if (out_sel == 2'b00) begin
                qv.push_back(model_out(ha, int'(coef_sel), 0));
                qd.push_back(cyc + 5); qt.push_back(tag);
            end
        end
        if (bv) begin
            for (int i = 0; i < 7; i++) hb[i] = hb[i+1];
            hb[7] = bs;
            if (out_sel == 2'b01) begin
                qv.push_back(model_out(hb, int'(coef_sel), 1));
                qd.push_back(cyc + 5); qt.push_back(tag);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, "idle");
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        check_out();
        a_vld = 0; b_vld = 0;
        cw_en = 1'b1; cw_addr = 9'(addr); cw_data = 10'(data);
        if (addr[8]) cm[addr[7:3]][addr[2]][addr[1:0]] = data;
    endtask

    function automatic int rs();
        return int'($urandom_range(1023)) - 512;
    endfunction

    task automatic stream(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            bit av = ($urandom_range(3) != 0);
            bit bv = ($urandom_range(2) != 0);
            step(av, rs(), bv, rs(), tag);
        end
        idle(8);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin ha[i] = 0; hb[i] = 0; end
        for (int s = 0; s < 32; s++) for (int c = 0; c < 2; c++) for (int k = 0; k < 4; k++) cm[s][c][k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 out_vld after reset", int'(out_vld), 0);
        check("R1 out_data after reset", int'(out_data), 0);

        // R1: zero bank gives zero results
        for (int i = 0; i < 10; i++) step(1, rs(), 1, rs(), "R1 zero bank");
        idle(8);

        // R5: set 0 for both channels at the documented addresses
        for (int k = 0; k < 4; k++) begin wr(9'h100 + k, rs()); wr(9'h104 + k, rs()); end
        idle(2);
        out_sel = 2'b00;
        stream(60, "R2 R3 channel A");
        out_sel = 2'b01;
        stream(60, "R9 channel B");

        // R6: writes below 0x100 alias nothing
        for (int k = 0; k < 8; k++) wr(k, rs());
        for (int k = 0; k < 20; k++) wr(int'($urandom_range(255)), rs());
        idle(2);
        out_sel = 2'b00;
        stream(30, "R6 after ignored writes A");
        out_sel = 2'b01;
        stream(30, "R6 after ignored writes B");

        // R7: other sets
        for (int k = 0; k < 8; k++) wr(9'h100 + 17*8 + k, rs());
        for (int k = 0; k < 8; k++) wr(9'h1F8 + k, rs());
        idle(2);
        coef_sel = 5'd17; out_sel = 2'b00;
        stream(40, "R7 set 17 A");
        coef_sel = 5'd31; out_sel = 2'b01;
        stream(40, "R7 set 31 B");
        coef_sel = 5'd0; out_sel = 2'b00;
        stream(20, "R7 back to set 0");

        // R10: full-scale negative
        for (int k = 0; k < 8; k++) wr(9'h110 + k, -512);
        idle(2);
        coef_sel = 5'd2; out_sel = 2'b00;
        for (int i = 0; i < 12; i++) step(1, -512, 1, 511, "R10 full scale A");
        idle(8);
        check("R10 full-scale value", int'(out_data), 4096);
        out_sel = 2'b01;
        for (int i = 0; i < 12; i++) step(1, -512, 1, -512, "R10 full scale B");
        idle(8);

        // R8: routing off
        out_sel = 2'b10;
        stream(20, "R8 off 10");
        check("R8 data held (10)", int'(out_data), int'(last_data));
        out_sel = 2'b11;
        stream(20, "R8 off 11");
        check("R8 data held (11)", int'(out_data), int'(last_data));
        check("R8 queue empty", qv.size(), 0);

        // R3: sparse strobes on A
        coef_sel = 5'd0; out_sel = 2'b00;
        for (int i = 0; i < 30; i++) begin
            step(1, rs(), 0, 0, "R3 sparse A");
            idle(int'($urandom_range(3)));
        end
        idle(8);
        check("R4 all results seen", qv.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 50000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule